// File: doc/BRIEF.md
# Glitch-Free Output Clock Router

The block takes three candidate clocks and routes them to two outputs: a main clock output and an auxiliary output. The main output always carries the PLL clock. The auxiliary output carries one of three things, chosen by a 2-bit source code: the reference clock, the clock input, or the PLL clock. A fourth code does not select a clock. Instead it drives the auxiliary output with a level that shows whether the PLL is unlocked. A configuration code paired with a mode pin can override the source code and force the auxiliary output onto the PLL clock.

Each output has its own enable. An optional auto-gating input stops both clock outputs while the PLL reports loss of lock. Gating and source changes pass through a handshake clocked on the falling edge of each source. A clock therefore stops and starts only while it is low, and a new source is switched on only after the previous one is confirmed off. Some changes are allowed to produce a partial period: entering or leaving the unlock-indicator code, and toggling the auxiliary enable while that code is selected.

Top module: `clk_router`

## Requirements
- R1: While rst_ni is low, main_clk_o and aux_clk_o are both low, whatever the enables and codes are.
- R2: When main_en_i is high and the output is not auto-gated, main_clk_o follows pll_clk_i. Turning main_en_i on or off never produces a high pulse or a low gap shorter than half a PLL period.
- R3: For source codes 2'b00, 2'b01 and 2'b10, toggling aux_en_i never produces a partial period on aux_clk_o. Each source stops and restarts only while it is low.
- R4: The source code aux_src_i selects ref_clk_i for 2'b00, in_clk_i for 2'b01 and pll_clk_i for 2'b10. Code 2'b11 selects the unlock indicator.
- R5: Switching between codes 2'b00 and 2'b10, even with rapid back-and-forth changes, produces no partial period. At most one source is gated onto aux_clk_o at any time.
- R6: With code 2'b11 and aux_en_i high, aux_clk_o equals NOT pll_locked_i, synchronized by two rising edges of ref_clk_i. It bypasses the clock gating. With aux_en_i low it is held low.
- R7: When mode_cfg_i is 3'b111 and mode_pin_i is high, the auxiliary output carries pll_clk_i whatever aux_src_i is. When mode_pin_i is low, aux_src_i governs. For any other mode_cfg_i value, mode_pin_i has no effect.
- R8: When auto_gate_i is high and pll_locked_i is low, both clock outputs stop at the low level without a partial period. They restart cleanly once lock returns.
- R9: When auto_gate_i is low, pll_locked_i has no effect on either clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock |
| in_clk_i | input | 1 | External clock input |
| pll_clk_i | input | 1 | PLL output clock |
| pll_locked_i | input | 1 | PLL lock status, high when locked |
| auto_gate_i | input | 1 | Gate both clock outputs while unlocked |
| main_en_i | input | 1 | Main output enable |
| aux_en_i | input | 1 | Auxiliary output enable |
| aux_src_i | input | 2 | Auxiliary source code (00 ref, 01 input, 10 PLL, 11 unlock level) |
| mode_cfg_i | input | 3 | Mode pin function code (3'b111 = force auxiliary to PLL) |
| mode_pin_i | input | 1 | Mode pin |
| main_clk_o | output | 1 | Main clock output |
| aux_clk_o | output | 1 | Auxiliary output |

## Verification
The bench builds the block with its defaults: two falling-edge handshake stages per source and two unlock synchronizer stages. It drives three mutually asynchronous clocks with half periods of 5, 7 and 3 ns. Codes and enables are toggled faster than a handshake completes, so sources are caught with a request still in flight. That is where a one-flop feedback or an early enable would show up as overlap or a runt. Every high pulse and low gap on both outputs is timed, and the width of a settled pulse identifies which source is active.

// File: rtl/clk_router_pkg.sv
`timescale 1ns/1ps
package clk_router_pkg;
  typedef enum logic [1:0] {
    AUX_REF    = 2'b00,
    AUX_IN     = 2'b01,
    AUX_PLL    = 2'b10,
    AUX_UNLOCK = 2'b11
  } aux_src_e;

  localparam int unsigned N_AUX_CLK = 3;
  localparam logic [2:0] CFG_AUX_FORCE = 3'b111;
endpackage

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
// Falling-edge enable pipeline; gated clock changes only while clk_i is low.
module clk_gate_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic on_o,
  output logic busy_o,
  output logic gclk_o
);
  logic [STAGES-1:0] q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], req_i};
  end

  assign on_o   = q[STAGES-1];
  assign busy_o = |q;
  assign gclk_o = clk_i & on_o;
endmodule

// File: rtl/clk_level_sync.sv
`timescale 1ns/1ps
module clk_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/clk_glitchless_mux.sv
`timescale 1ns/1ps
// One-hot select; a source may start only when every other source is fully idle.
module clk_glitchless_mux #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] clk_i,
  input  logic [N_SRC-1:0] sel_i,
  output logic [N_SRC-1:0] on_o,
  output logic             clk_o
);
  logic [N_SRC-1:0] busy;
  logic [N_SRC-1:0] gclk;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic [N_SRC-1:0] others;
    logic             req;

    assign others = busy & ~(N_SRC'(1) << k);
    assign req    = sel_i[k] & ~(|others);

    clk_gate_cell #(.STAGES(STAGES)) u_gate (
      .clk_i  (clk_i[k]),
      .rst_ni (rst_ni),
      .req_i  (req),
      .on_o   (on_o[k]),
      .busy_o (busy[k]),
      .gclk_o (gclk[k])
    );
  end

  assign clk_o = |gclk;
endmodule

// File: rtl/clk_router.sv
`timescale 1ns/1ps
module clk_router
  import clk_router_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned UNLOCK_STAGES = 2
) (
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       in_clk_i,
  input  logic       pll_clk_i,
  input  logic       pll_locked_i,
  input  logic       auto_gate_i,
  input  logic       main_en_i,
  input  logic       aux_en_i,
  input  logic [1:0] aux_src_i,
  input  logic [2:0] mode_cfg_i,
  input  logic       mode_pin_i,
  output logic       main_clk_o,
  output logic       aux_clk_o
);
  localparam int unsigned NA = N_AUX_CLK;

  logic          gate_off;
  logic          main_req;
  logic [0:0]    main_on;
  logic          force_pll;
  aux_src_e      aux_code;
  logic          aux_run;
  logic [NA-1:0] aux_sel;
  logic [NA-1:0] aux_on;
  logic [NA-1:0] aux_clks;
  logic          aux_mux_clk;
  logic          unlock_q;

  assign gate_off  = auto_gate_i & ~pll_locked_i;
  assign main_req  = main_en_i & ~gate_off;
  assign force_pll = (mode_cfg_i == CFG_AUX_FORCE) & mode_pin_i;
  assign aux_code  = force_pll ? AUX_PLL : aux_src_e'(aux_src_i);
  assign aux_run   = aux_en_i & ~gate_off;
  assign aux_clks  = {pll_clk_i, in_clk_i, ref_clk_i};

  always_comb begin
    for (int k = 0; k < int'(NA); k++)
      aux_sel[k] = aux_run && (aux_code == aux_src_e'(k));
  end

  clk_glitchless_mux #(.N_SRC(1), .STAGES(SYNC_STAGES)) u_main (
    .rst_ni (rst_ni),
    .clk_i  (pll_clk_i),
    .sel_i  (main_req),
    .on_o   (main_on),
    .clk_o  (main_clk_o)
  );

  clk_glitchless_mux #(.N_SRC(NA), .STAGES(SYNC_STAGES)) u_aux (
    .rst_ni (rst_ni),
    .clk_i  (aux_clks),
    .sel_i  (aux_sel),
    .on_o   (aux_on),
    .clk_o  (aux_mux_clk)
  );

  clk_level_sync #(.STAGES(UNLOCK_STAGES)) u_unlock (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (~pll_locked_i),
    .q_o    (unlock_q)
  );

  // Unlock level bypasses gating: partial periods allowed on entry/exit.
  assign aux_clk_o = (aux_code == AUX_UNLOCK) ? (aux_en_i & unlock_q) : aux_mux_clk;
endmodule

// File: rtl/clk_router_chk.sv
`timescale 1ns/1ps
module clk_router_chk #(
  parameter int unsigned NA     = 3,
  parameter int unsigned STAGES = 2
) (
  input logic          rst_ni,
  input logic          ref_clk_i,
  input logic          pll_clk_i,
  input logic [NA-1:0] src_clk,
  input logic          main_req,
  input logic          main_on,
  input logic [NA-1:0] aux_on
);
  // R2: main enable state only changes while the PLL clock is low
  always @(main_on) begin
    if (rst_ni) a_r2_main_switch_low: assert (!pll_clk_i)
      else $error("main gate changed with pll_clk_i high");
  end

  // R3: each auxiliary source turns on/off only while that source is low
  for (genvar k = 0; k < NA; k++) begin : g_aux
    always @(aux_on[k]) begin
      if (rst_ni) a_r3_aux_switch_low: assert (!src_clk[k])
        else $error("aux gate %0d changed with its clock high", k);
    end
  end

  // R5: never two auxiliary sources on at once
  a_r5_aux_exclusive: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $onehot0(aux_on));

  // R8: a dropped request reaches the main gate after the pipeline depth
  if (STAGES == 2) begin : g_drop
    a_r8_main_drops: assert property (@(negedge pll_clk_i) disable iff (!rst_ni)
      ($past(main_req, 2) == 1'b0) |-> !main_on);
  end
endmodule

bind clk_router clk_router_chk #(.NA(N_AUX_CLK), .STAGES(SYNC_STAGES)) u_chk (
  .rst_ni    (rst_ni),
  .ref_clk_i (ref_clk_i),
  .pll_clk_i (pll_clk_i),
  .src_clk   ({pll_clk_i, in_clk_i, ref_clk_i}),
  .main_req  (main_req),
  .main_on   (main_on[0]),
  .aux_on    (aux_on)
);

// File: tb/clk_router_tb_top.sv
`timescale 1ns/1ps
module clk_router_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam real REF_HALF   = CLK_PERIOD / 2.0;
  localparam real IN_HALF    = 7.0;
  localparam real PLL_HALF   = 3.0;
  localparam real MIN_PHASE  = 2.9;

  logic rst_ni = 1'b0;
  logic ref_clk = 1'b0, in_clk = 1'b0, pll_clk = 1'b0;
  logic locked = 1'b1, auto_gate = 1'b0, main_en = 1'b0, aux_en = 1'b0;
  logic [1:0] aux_src = 2'b00;
  logic [2:0] mode_cfg = 3'b000;
  logic mode_pin = 1'b0;
  logic main_clk, aux_clk;

  int n_tests = 0, n_fail = 0;

  clk_router dut_i (
    .rst_ni(rst_ni), .ref_clk_i(ref_clk), .in_clk_i(in_clk), .pll_clk_i(pll_clk),
    .pll_locked_i(locked), .auto_gate_i(auto_gate), .main_en_i(main_en),
    .aux_en_i(aux_en), .aux_src_i(aux_src), .mode_cfg_i(mode_cfg),
    .mode_pin_i(mode_pin), .main_clk_o(main_clk), .aux_clk_o(aux_clk)
  );

  initial begin #1.3; forever #(REF_HALF) ref_clk = ~ref_clk; end
  initial begin #2.7; forever #(IN_HALF)  in_clk  = ~in_clk;  end
  initial begin #0.4; forever #(PLL_HALF) pll_clk = ~pll_clk; end

  // pulse monitors
  real m_rise = -1.0, m_fall = -1.0, m_hi = 0.0;
  real a_rise = -1.0, a_fall = -1.0, a_hi = 0.0;
  int  m_runts = 0, a_runts = 0, m_edges = 0, a_edges = 0;
  bit  a_ignore = 1'b0;

  always @(posedge main_clk) begin
    m_edges++;
    if (m_fall >= 0.0 && $realtime - m_fall < MIN_PHASE) m_runts++;
    m_rise = $realtime;
  end
  always @(negedge main_clk) begin
    if (m_rise >= 0.0) begin
      m_hi = $realtime - m_rise;
      if (m_hi < MIN_PHASE) m_runts++;
    end
    m_fall = $realtime;
  end
  always @(posedge aux_clk) begin
    a_edges++;
    if (!a_ignore && a_fall >= 0.0 && $realtime - a_fall < MIN_PHASE) a_runts++;
    a_rise = $realtime;
  end
  always @(negedge aux_clk) begin
    if (a_rise >= 0.0) begin
      a_hi = $realtime - a_rise;
      if (!a_ignore && a_hi < MIN_PHASE) a_runts++;
    end
    a_fall = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic t_reset();
    main_en = 1'b1; aux_en = 1'b1; aux_src = 2'b00;
    #20;
    check(main_clk == 1'b0, "R1", "main in reset", main_clk, 0);
    check(aux_clk == 1'b0, "R1", "aux in reset", aux_clk, 0);
    #30 rst_ni = 1'b1;
    #150;
  endtask

  task automatic t_main_enable();
    int r0 = m_runts;
    int e0;
    check(near(m_hi, PLL_HALF), "R2", "main high width", m_hi, PLL_HALF);
    for (int i = 0; i < 16; i++) begin
      main_en = ~main_en;
      #(5 + (i * 7) % 19);
    end
    main_en = 1'b0;
    #100;
    e0 = m_edges;
    #100;
    check(m_edges == e0 && main_clk == 1'b0, "R2", "main quiet when disabled", m_edges - e0, 0);
    main_en = 1'b1;
    #150;
    check(m_runts == r0, "R2", "main runts on enable toggles", m_runts - r0, 0);
    check(near(m_hi, PLL_HALF), "R2", "main width after re-enable", m_hi, PLL_HALF);
  endtask

  task automatic t_codes();
    aux_src = 2'b00; #150;
    check(near(a_hi, REF_HALF), "R4", "code 00 selects ref", a_hi, REF_HALF);
    aux_src = 2'b01; #150;
    check(near(a_hi, IN_HALF), "R4", "code 01 selects input", a_hi, IN_HALF);
    aux_src = 2'b10; #150;
    check(near(a_hi, PLL_HALF), "R4", "code 10 selects pll", a_hi, PLL_HALF);
  endtask

  task automatic t_aux_enable();
    int r0 = a_runts;
    for (int s = 0; s < 2; s++) begin
      aux_src = s[0] ? 2'b01 : 2'b00;
      #150;
      for (int i = 0; i < 14; i++) begin
        aux_en = ~aux_en;
        #(4 + (i * 11) % 23);
      end
      aux_en = 1'b1;
      #150;
    end
    check(a_runts == r0, "R3", "aux runts on enable toggles", a_runts - r0, 0);
    check(near(a_hi, IN_HALF), "R3", "aux resumes on input clock", a_hi, IN_HALF);
  endtask

  task automatic t_switch();
    int r0;
    aux_src = 2'b00; #150;
    r0 = a_runts;
    for (int i = 0; i < 24; i++) begin
      aux_src = (aux_src == 2'b00) ? 2'b10 : 2'b00;
      #(3 + (i * 13) % 29);
    end
    aux_src = 2'b10; #150;
    check(a_runts == r0, "R5", "runts on 00/10 switching", a_runts - r0, 0);
    check(near(a_hi, PLL_HALF), "R5", "lands on pll", a_hi, PLL_HALF);
  endtask

  task automatic t_unlock();
    int e0;
    a_ignore = 1'b1;
    aux_src = 2'b11; locked = 1'b0; #40;
    check(aux_clk == 1'b1, "R6", "unlock level high", aux_clk, 1);
    e0 = a_edges; #100;
    check(a_edges == e0 && aux_clk == 1'b1, "R6", "level steady, no clock", a_edges - e0, 0);
    locked = 1'b1; #40;
    check(aux_clk == 1'b0, "R6", "locked gives low", aux_clk, 0);
    aux_en = 1'b0; locked = 1'b0; #40;
    check(aux_clk == 1'b0, "R6", "disabled indicator low", aux_clk, 0);
    locked = 1'b1; aux_en = 1'b1; aux_src = 2'b00; #150;
    a_ignore = 1'b0;
  endtask

  task automatic t_force();
    int r0 = a_runts;
    aux_src = 2'b00; mode_cfg = 3'b111; mode_pin = 1'b1; #150;
    check(near(a_hi, PLL_HALF), "R7", "pin forces pll", a_hi, PLL_HALF);
    mode_pin = 1'b0; #150;
    check(near(a_hi, REF_HALF), "R7", "pin low returns to code", a_hi, REF_HALF);
    mode_cfg = 3'b110; mode_pin = 1'b1; #150;
    check(near(a_hi, REF_HALF), "R7", "other cfg ignores pin", a_hi, REF_HALF);
    mode_cfg = 3'b111; aux_src = 2'b01; #150;
    check(near(a_hi, PLL_HALF), "R7", "force overrides code 01", a_hi, PLL_HALF);
    aux_src = 2'b00; #150;
    r0 = a_runts;
    for (int i = 0; i < 12; i++) begin
      mode_pin = ~mode_pin;
      #(6 + (i * 5) % 17);
    end
    mode_pin = 1'b0; mode_cfg = 3'b000; #150;
    check(a_runts == r0, "R7", "runts on pin toggles", a_runts - r0, 0);
  endtask

  task automatic t_auto_gate();
    int rm = m_runts, ra = a_runts, em, ea;
    auto_gate = 1'b1; aux_src = 2'b00; #150;
    locked = 1'b0; #100;
    em = m_edges; ea = a_edges; #100;
    check(m_edges == em && main_clk == 1'b0, "R8", "main stopped low", m_edges - em, 0);
    check(a_edges == ea && aux_clk == 1'b0, "R8", "aux stopped low", a_edges - ea, 0);
    locked = 1'b1; #150;
    check(m_runts == rm && a_runts == ra, "R8", "runts around gating",
          (m_runts - rm) + (a_runts - ra), 0);
    check(near(m_hi, PLL_HALF) && near(a_hi, REF_HALF), "R8", "both resume", a_hi, REF_HALF);
  endtask

  task automatic t_no_auto();
    int em, ea;
    auto_gate = 1'b0; locked = 1'b0; #100;
    em = m_edges; ea = a_edges; #100;
    check(m_edges > em && near(m_hi, PLL_HALF), "R9", "main runs unlocked", m_hi, PLL_HALF);
    check(a_edges > ea && near(a_hi, REF_HALF), "R9", "aux runs unlocked", a_hi, REF_HALF);
    locked = 1'b1;
  endtask

  initial begin
    t_reset();
    t_main_enable();
    t_codes();
    t_aux_enable();
    t_switch();
    t_unlock();
    t_force();
    t_auto_gate();
    t_no_auto();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule